// File: doc/BRIEF.md
# External Bus Address Decoder for a Signal Processor

This block sits between the external memory interface of a 16-bit signal processor and the devices hung on that bus. It watches the address lines, the three address-space strobes (program, data, I/O), the read and write strobes, a two-bit program page extension and a boot/download mode pin. From them it produces chip selects and read/write strobes for a 64K×16 RAM, a 256K×16 flash, the read port of an image capture FIFO and an eight-register UART. It also forwards the UART interrupt line.

All outputs are registered. The decode of the bus state sampled at one rising clock edge appears on the outputs right after that edge. Every select and strobe is active low. The mode pin moves the upper half of flash page 0 between the two spaces. With the pin low (download), that half answers in data space and may be written. With the pin high (boot), it answers in program space, and the whole flash is read-only.

Top module: `bus_decode`

## Requirements
- R1: While `rst_n` is low, every select and strobe output is high, `flash_page` and `uart_reg` are 0 and `uart_irq` is 0.
- R2: An access is recognised only when exactly one of `prog_n`, `data_n`, `io_n` is low and exactly one of `rd_n`, `wr_n` is low. Otherwise no select is active. At most one of `ram_ce_n`, `flash_ce_n`, `fifo_rd_n`, `uart_cs_n` is low in any cycle.
- R3: The RAM is selected in program space at addresses 0x0000–0x3FFF when `prog_page` is 0. It is also selected in data space at addresses 0x8000–0xFFFF when `boot_sel` is 1.
- R4: With `boot_sel` 0, data-space addresses 0x8000–0xFFFF select the flash with `flash_page` 0, and the RAM stays deselected.
- R5: In program space the flash is selected for three ranges. With page 0, it answers at 0x4000–0x7FFF, and at 0x8000–0xFFFF when `boot_sel` is 1. With pages 1 and 2, it answers at every address. Page 3 selects nothing. In program space `flash_page` equals `prog_page`, and elsewhere it is 0.
- R6: With `boot_sel` 1, a write to any flash address produces no select: `flash_ce_n` and `flash_we_n` stay high.
- R7: An I/O read with address bits [15:14] = 01 drives `fifo_rd_n` low. An I/O write there produces no select.
- R8: I/O addresses 0x8000–0x8007 select the UART. `uart_reg` always carries address bits [2:0]. Any other I/O address outside the FIFO window selects nothing.
- R9: A selected device gets its read strobe low on a read and its write strobe low on a write. No read or write strobe is low without its device's chip select.
- R10: `uart_irq` equals `uart_irq_in` delayed by one clock.
- R11: Every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Processor address bus |
| prog_page | input | 2 | Program address extension, bits 17:16 |
| prog_n | input | 1 | Program space strobe, active low |
| data_n | input | 1 | Data space strobe, active low |
| io_n | input | 1 | I/O space strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| boot_sel | input | 1 | 1 = boot (flash upper page-0 half in program space, flash read-only), 0 = download |
| uart_irq_in | input | 1 | Interrupt from the UART |
| ram_ce_n | output | 1 | RAM chip select |
| ram_oe_n | output | 1 | RAM output enable |
| ram_we_n | output | 1 | RAM write enable |
| flash_ce_n | output | 1 | Flash chip select |
| flash_oe_n | output | 1 | Flash output enable |
| flash_we_n | output | 1 | Flash write enable |
| flash_page | output | 2 | Flash address bits 17:16 |
| fifo_rd_n | output | 1 | FIFO read strobe |
| uart_cs_n | output | 1 | UART chip select |
| uart_rd_n | output | 1 | UART read strobe |
| uart_wr_n | output | 1 | UART write strobe |
| uart_reg | output | 3 | UART register select |
| uart_irq | output | 1 | Forwarded UART interrupt |

## Verification
Several properties are checked every cycle: that the four device selects stay mutually exclusive, that an idle bus leaves them all high, and that read and write strobes never appear without their chip select. The same checks cover the read-only flash in boot mode, the write-proof FIFO port, the UART register bits and the interrupt delay. The memory map itself is shown only by the bench's scenarios. These include the mode pin moving the flash between spaces, RAM winning the low program window, pages 1 to 3, the exact UART window edges 0x7FFF/0x8007/0x8008, and illegal strobe combinations.

// File: rtl/bus_decode.sv
module bus_decode #(
  parameter int AW = 16,
  parameter int PW = 2,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [PW-1:0] prog_page,
  input  logic          prog_n,
  input  logic          data_n,
  input  logic          io_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          boot_sel,
  input  logic          uart_irq_in,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic          flash_ce_n,
  output logic          flash_oe_n,
  output logic          flash_we_n,
  output logic [PW-1:0] flash_page,
  output logic          fifo_rd_n,
  output logic          uart_cs_n,
  output logic          uart_rd_n,
  output logic          uart_wr_n,
  output logic [RW-1:0] uart_reg,
  output logic          uart_irq
);
  localparam logic [AW-RW-1:0] UART_BASE = (AW-RW)'(1 << (AW-1-RW));

  logic one_space, is_rd, is_wr, acc;
  logic in_prog, in_data, in_io;
  logic [1:0] top2;
  logic pg0, pg_ext;
  logic ram_hit, flash_map, flash_hit, fifo_hit, uart_hit;

  assign one_space = $countones({~prog_n, ~data_n, ~io_n}) == 1;
  assign is_rd     = ~rd_n & wr_n;
  assign is_wr     = ~wr_n & rd_n;
  assign acc       = one_space & (is_rd | is_wr);
  assign in_prog   = acc & ~prog_n;
  assign in_data   = acc & ~data_n;
  assign in_io     = acc & ~io_n;
  assign top2      = bus_addr[AW-1:AW-2];
  assign pg0       = prog_page == '0;
  assign pg_ext    = prog_page == PW'(1) || prog_page == PW'(2);

  assign ram_hit   = (in_prog & pg0 & top2 == 2'b00)
                   | (in_data & top2[1] & boot_sel);
  assign flash_map = (in_prog & pg0 & top2 == 2'b01)
                   | (in_prog & pg0 & top2[1] & boot_sel)
                   | (in_prog & pg_ext)
                   | (in_data & top2[1] & ~boot_sel);
  assign flash_hit = flash_map & ~(is_wr & boot_sel);
  assign fifo_hit  = in_io & top2 == 2'b01 & is_rd;
  assign uart_hit  = in_io & bus_addr[AW-1:RW] == UART_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_ce_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_we_n   <= 1'b1;
      flash_ce_n <= 1'b1;
      flash_oe_n <= 1'b1;
      flash_we_n <= 1'b1;
      flash_page <= '0;
      fifo_rd_n  <= 1'b1;
      uart_cs_n  <= 1'b1;
      uart_rd_n  <= 1'b1;
      uart_wr_n  <= 1'b1;
      uart_reg   <= '0;
      uart_irq   <= 1'b0;
    end else begin
      ram_ce_n   <= ~ram_hit;
      ram_oe_n   <= ~(ram_hit & is_rd);
      ram_we_n   <= ~(ram_hit & is_wr);
      flash_ce_n <= ~flash_hit;
      flash_oe_n <= ~(flash_hit & is_rd);
      flash_we_n <= ~(flash_hit & is_wr);
      flash_page <= (one_space & ~prog_n) ? prog_page : '0;
      fifo_rd_n  <= ~fifo_hit;
      uart_cs_n  <= ~uart_hit;
      uart_rd_n  <= ~(uart_hit & is_rd);
      uart_wr_n  <= ~(uart_hit & is_wr);
      uart_reg   <= bus_addr[RW-1:0];
      uart_irq   <= uart_irq_in;
    end
  end
endmodule

// File: rtl/bus_decode_chk.sv
module bus_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr_lo,
  input logic       prog_n,
  input logic       data_n,
  input logic       io_n,
  input logic       wr_n,
  input logic       boot_sel,
  input logic       uart_irq_in,
  input logic       ram_ce_n,
  input logic       ram_oe_n,
  input logic       ram_we_n,
  input logic       flash_ce_n,
  input logic       flash_oe_n,
  input logic       flash_we_n,
  input logic       fifo_rd_n,
  input logic       uart_cs_n,
  input logic       uart_rd_n,
  input logic       uart_wr_n,
  input logic [2:0] uart_reg,
  input logic       uart_irq
);
  AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_ce_n, ~flash_ce_n, ~fifo_rd_n, ~uart_cs_n}) <= 1); // R2

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_n && data_n && io_n) |=> (ram_ce_n && flash_ce_n && fifo_rd_n && uart_cs_n)); // R2

  AST_FLASH_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_sel && !wr_n) |=> (flash_ce_n && flash_we_n)); // R6

  AST_FIFO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_n && !wr_n) |=> fifo_rd_n); // R7

  AST_UART_REG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_cs_n |-> uart_reg == $past(addr_lo)); // R8

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ram_oe_n || !ram_we_n) |-> !ram_ce_n) and
    ((!flash_oe_n || !flash_we_n) |-> !flash_ce_n) and
    ((!uart_rd_n || !uart_wr_n) |-> !uart_cs_n)); // R9

  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> uart_irq == $past(uart_irq_in)); // R10
endmodule

bind bus_decode bus_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_lo(bus_addr[2:0]),
  .prog_n(prog_n), .data_n(data_n), .io_n(io_n), .wr_n(wr_n),
  .boot_sel(boot_sel), .uart_irq_in(uart_irq_in),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
  .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
  .fifo_rd_n(fifo_rd_n), .uart_cs_n(uart_cs_n), .uart_rd_n(uart_rd_n),
  .uart_wr_n(uart_wr_n), .uart_reg(uart_reg), .uart_irq(uart_irq)
);

// File: tb/sim_bus_decode.sv
`timescale 1ns/1ps
module sim_bus_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  prog_page = '0;
  logic prog_n = 1'b1, data_n = 1'b1, io_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic boot_sel = 1'b0, uart_irq_in = 1'b0;
  logic ram_ce_n, ram_oe_n, ram_we_n, flash_ce_n, flash_oe_n, flash_we_n;
  logic [1:0] flash_page;
  logic fifo_rd_n, uart_cs_n, uart_rd_n, uart_wr_n, uart_irq;
  logic [2:0] uart_reg;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_decode u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .prog_page(prog_page),
    .prog_n(prog_n), .data_n(data_n), .io_n(io_n), .rd_n(rd_n), .wr_n(wr_n),
    .boot_sel(boot_sel), .uart_irq_in(uart_irq_in),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_page(flash_page), .fifo_rd_n(fifo_rd_n), .uart_cs_n(uart_cs_n),
    .uart_rd_n(uart_rd_n), .uart_wr_n(uart_wr_n), .uart_reg(uart_reg),
    .uart_irq(uart_irq)
  );

  // packing: ram ce/oe/we, flash ce/oe/we, flash_page, fifo, uart cs/rd/wr, uart_reg, irq
  function automatic logic [15:0] outs();
    return {ram_ce_n, ram_oe_n, ram_we_n, flash_ce_n, flash_oe_n, flash_we_n,
            flash_page, fifo_rd_n, uart_cs_n, uart_rd_n, uart_wr_n, uart_reg, uart_irq};
  endfunction

  function automatic logic [15:0] expect_of(
      input logic [15:0] a, input logic [1:0] pg, input logic p, d, i, r, w, bs, irq);
    logic rd, wr, ram, fl, ff, ua;
    int spaces;
    spaces = int'(!p) + int'(!d) + int'(!i);
    rd = !r && w;
    wr = !w && r;
    ram = 0; fl = 0; ff = 0; ua = 0;
    if (spaces == 1 && (rd || wr)) begin
      if (!p) begin
        if (pg == 2'd0 && a < 16'h4000) ram = 1;
        else if (pg == 2'd0 && a < 16'h8000) fl = 1;
        else if (pg == 2'd0) fl = bs;
        else if (pg != 2'd3) fl = 1;
      end else if (!d) begin
        if (a >= 16'h8000) begin
          if (bs) ram = 1; else fl = 1;
        end
      end else begin
        if (a >= 16'h4000 && a < 16'h8000) ff = rd;
        if (a >= 16'h8000 && a <= 16'h8007) ua = 1;
      end
      if (bs && wr) fl = 0;
    end
    return {!ram, !(ram && rd), !(ram && wr), !fl, !(fl && rd), !(fl && wr),
            (spaces == 1 && !p) ? pg : 2'b00, !ff, !ua, !(ua && rd), !(ua && wr),
            a[2:0], irq};
  endfunction

  function automatic string tag_of(input logic [15:0] e);
    if (!e[15]) return "R3";
    if (!e[12]) return (e[9:8] == 2'b00 && !data_n) ? "R4" : "R5";
    if (!e[7])  return "R7";
    if (!e[6])  return "R8";
    return "R2";
  endfunction

  task automatic drive(input logic [15:0] a, input logic [1:0] pg,
                       input logic p, d, i, r, w, bs, irq);
    @(negedge clk);
    bus_addr = a; prog_page = pg; prog_n = p; data_n = d; io_n = i;
    rd_n = r; wr_n = w; boot_sel = bs; uart_irq_in = irq;
  endtask

  // R11: outputs are sampled 1 ns after the edge that registered the inputs
  task automatic apply(input logic [15:0] a, input logic [1:0] pg,
                       input logic p, d, i, r, w, bs, irq, input string req);
    logic [15:0] e, g;
    drive(a, pg, p, d, i, r, w, bs, irq);
    e = expect_of(a, pg, p, d, i, r, w, bs, irq);
    @(posedge clk); #1;
    g = outs();
    n_vec++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h page=%0d sp=%b%b%b rd_n=%b wr_n=%b boot=%b: got %b expected %b",
               (req == "") ? tag_of(e) : req, a, pg, p, d, i, r, w, bs, g, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    bus_addr = 16'h8003; prog_n = 1'b0; rd_n = 1'b0; uart_irq_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (outs() !== 16'b1111_1100_1111_0000) begin // R1
      n_bad++;
      $display("FAIL R1 reset state: got %b expected %b", outs(), 16'b1111_1100_1111_0000);
    end
    @(negedge clk); rst_n = 1'b1;

    // R3 RAM windows
    apply(16'h0000, 2'd0, 0,1,1, 0,1, 0, 0, "R3");
    apply(16'h3FFF, 2'd0, 0,1,1, 1,0, 1, 0, "R3");
    apply(16'h8000, 2'd3, 1,0,1, 0,1, 1, 0, "R3");
    apply(16'hFFFF, 2'd0, 1,0,1, 1,0, 1, 1, "R3");
    apply(16'h7FFF, 2'd0, 1,0,1, 0,1, 1, 0, "R3");
    // R4 flash in data space during download, write allowed
    apply(16'h8000, 2'd2, 1,0,1, 0,1, 0, 0, "R4");
    apply(16'hC123, 2'd0, 1,0,1, 1,0, 0, 0, "R4");
    // R5 flash in program space
    apply(16'h4000, 2'd0, 0,1,1, 0,1, 0, 0, "R5");
    apply(16'h9000, 2'd0, 0,1,1, 0,1, 1, 0, "R5");
    apply(16'h9000, 2'd0, 0,1,1, 0,1, 0, 0, "R5");
    apply(16'h0010, 2'd1, 0,1,1, 0,1, 1, 0, "R5");
    apply(16'hFFFF, 2'd2, 0,1,1, 0,1, 0, 1, "R5");
    apply(16'h1234, 2'd3, 0,1,1, 0,1, 1, 0, "R5");
    // R6 flash writes in boot mode are ignored
    apply(16'h4000, 2'd0, 0,1,1, 1,0, 1, 0, "R6");
    apply(16'h2000, 2'd1, 0,1,1, 1,0, 1, 0, "R6");
    // R7 FIFO read port
    apply(16'h4000, 2'd0, 1,1,0, 0,1, 0, 0, "R7");
    apply(16'h7FFF, 2'd0, 1,1,0, 1,0, 0, 0, "R7");
    // R8 UART window edges
    apply(16'h8000, 2'd0, 1,1,0, 0,1, 0, 0, "R8");
    apply(16'h8007, 2'd0, 1,1,0, 1,0, 0, 1, "R8");
    apply(16'h8008, 2'd0, 1,1,0, 0,1, 0, 0, "R8");
    apply(16'h3FFF, 2'd0, 1,1,0, 0,1, 0, 0, "R8");
    // R9 strobe direction; R2 illegal combinations
    apply(16'h0100, 2'd0, 0,1,1, 0,0, 0, 0, "R2");
    apply(16'h0100, 2'd0, 0,0,1, 0,1, 0, 0, "R2");
    apply(16'h8001, 2'd0, 1,1,1, 0,1, 0, 0, "R2");
    apply(16'h0100, 2'd0, 0,1,1, 1,0, 0, 0, "R9");
    // R10 interrupt delay
    apply(16'h0000, 2'd0, 1,1,1, 1,1, 0, 1, "R10");
    apply(16'h0000, 2'd0, 1,1,1, 1,1, 0, 0, "R10");

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      logic p, d, i, r, w;
      int s, rw;
      s = $urandom % 8;
      rw = $urandom % 6;
      p = 1; d = 1; i = 1;
      case (s)
        0, 1: p = 0;
        2, 3: d = 0;
        4, 5: i = 0;
        6: ;
        default: begin p = $urandom % 2; d = $urandom % 2; i = 0; end
      endcase
      r = !(rw < 3);
      w = !(rw == 3 || rw == 4);
      if (rw == 5) begin r = $urandom % 2; w = r; end
      a = 16'($urandom);
      if ($urandom % 4 == 0) a = 16'h8000 | 16'($urandom % 10);
      apply(a, 2'($urandom), p, d, i, r, w, 1'($urandom), 1'($urandom), "");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule